// File: doc/BRIEF.md
# Timer Clock Source Prescaler

This block produces the count-enable tick for a CPU timer. It takes the system clock and a set of unrelated clock inputs. A 6-bit configuration word chooses the source. For the system clock, the tick is high on every cycle and the prescaler is skipped. For an alternate clock, the chosen clock is divided by a power of two in its own domain. The divided level then passes through a two-flop synchronizer, and each rising edge of it becomes a single-cycle tick in the system clock domain.

The configuration word holds a 3-bit source code and a 3-bit prescale code. An accepted write opens a hold-off window of 45 system clock cycles. During the window, `cfg_busy` is high, further writes are dropped and the tick is held low. This means the timer never counts while the synchronizer carries levels from the old source. For correct counting, the system clock must run at least twice as fast as the divided clock.

Top module: `tmr_clk_presc`

## Requirements
- R1: While reset is asserted and after it is released, `cfg_rdata` reads 0 and `cfg_busy` is low.
- R2: With source code 0, `tick` is high on every cycle in which `cfg_busy` is low, whatever the prescale code.
- R3: Source codes 1 to 4 select `alt_clk[code-1]`. Each rising edge of the divided alternate clock gives exactly one tick, and that tick lasts one cycle.
- R4: Prescale codes 0, 1, 2, 3 and 4 divide the alternate clock by 1, 2, 4, 8 and 16.
- R5: The write data field positions are: bits 2:0 are the source code and bits 5:3 are the prescale code. A write with `cfg_busy` low is stored and read back on `cfg_rdata` after the clock edge. `cfg_busy` is then high for exactly 45 cycles.
- R6: A write presented while `cfg_busy` is high leaves `cfg_rdata` unchanged and does not restart the window. A write at the 45th edge after an accepted write is dropped. A write at the 46th edge is accepted.
- R7: `tick` is low on every cycle in which `cfg_busy` is high.
- R8: Source codes 5, 6 and 7 produce no ticks.
- R9: Prescale codes 5, 6 and 7 divide by 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, used by both domains |
| alt_clk | input | NUM_ALT (4) | Alternate clock inputs, unrelated to `clk` |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Write data: bits 5:3 hold the prescale code, bits 2:0 the source code |
| cfg_rdata | output | 6 | Stored configuration word |
| cfg_busy | output | 1 | Hold-off window active; writes are dropped |
| tick | output | 1 | Single-cycle timer count enable |

## Verification
A wrong prescale decode or source mux shows as a tick rate off by a factor of two or more. It is therefore measured as a tick count over a long window and compared with the rising edges the bench counts on the alternate clock itself. A wrong hold-off counter shows within a write or two: `cfg_busy` has the wrong length, a write at the 45th or 46th edge lands on the wrong side, or a tick appears while busy. Broken synchronizer or edge logic appears as double-width ticks or as ticks on a reserved source within the first measurement window.

// File: rtl/tcp_pkg.sv
`timescale 1ns/1ps
package tcp_pkg;

    localparam int SRC_W = 3;
    localparam int PSC_W = 3;
    localparam int CFG_W = SRC_W + PSC_W;

    // Prescale in bits 5:3, source in bits 2:0 (software-visible layout)
    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic [SRC_W-1:0] src;
    } tcp_cfg_t;

    // Log2 of the divide ratio; codes above the largest ratio clamp to it
    function automatic int unsigned psc_log(input logic [PSC_W-1:0] code,
                                            input int unsigned max_log);
        if (int'(code) > int'(max_log)) return max_log;
        return int'(code);
    endfunction

endpackage

// File: rtl/tcp_cfg_guard.sv
`timescale 1ns/1ps
module tcp_cfg_guard
    import tcp_pkg::*;
#(
    parameter int HOLD_CYC = 45
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     we,
    input  tcp_cfg_t wdata,
    output tcp_cfg_t cfg_o,
    output logic     busy_o,
    output logic     busy_next_o
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        tcp_cfg_t         cfg;
        logic [CNT_W-1:0] hold;
    } guard_st_t;

    guard_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.hold != '0) begin
            st_d.hold = st_q.hold - 1'b1;
        end
        if (we && (st_q.hold == '0)) begin
            st_d.cfg  = wdata;
            st_d.hold = CNT_W'(HOLD_CYC);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o       = st_q.cfg;
    assign busy_o      = (st_q.hold != '0);
    assign busy_next_o = (st_d.hold != '0);

endmodule

// File: rtl/tcp_src_div.sv
`timescale 1ns/1ps
module tcp_src_div #(
    parameter int DIV_LOG = 4
) (
    input  logic             aclk,
    input  logic             rst_n,
    output logic [DIV_LOG:0] tap_o
);
    logic [DIV_LOG-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge aclk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // tap k is the source divided by 2**k; tap 0 is the source itself
    assign tap_o = {cnt_q, aclk};

endmodule

// File: rtl/tcp_tick_gen.sv
`timescale 1ns/1ps
module tcp_tick_gen
    import tcp_pkg::*;
#(
    parameter int NUM_ALT = 4,
    parameter int DIV_LOG = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_ALT-1:0][DIV_LOG:0]  taps,
    input  tcp_cfg_t                       cfg,
    input  logic                           quiet_next,
    output logic                           tick_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
        logic tick;
    } tick_st_t;

    tick_st_t st_d, st_q;

    logic             alt_ok;
    logic             lvl;
    logic             rise;
    logic [DIV_LOG:0] row;
    int unsigned      plog;

    always_comb begin
        row    = '0;
        alt_ok = 1'b0;
        for (int i = 0; i < NUM_ALT; i++) begin
            if (cfg.src == SRC_W'(i + 1)) begin
                row    = taps[i];
                alt_ok = 1'b1;
            end
        end
        plog = psc_log(cfg.psc, DIV_LOG);
        lvl  = 1'b0;
        for (int j = 0; j <= DIV_LOG; j++) begin
            if (plog == j) lvl = row[j];
        end

        rise       = st_q.s2 & ~st_q.prev;
        st_d.s1    = lvl;
        st_d.s2    = st_q.s1;
        st_d.prev  = st_q.s2;
        st_d.tick  = ~quiet_next &
                     ((cfg.src == '0) | (alt_ok & rise));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;

endmodule

// File: rtl/tmr_clk_presc.sv
`timescale 1ns/1ps
module tmr_clk_presc
    import tcp_pkg::*;
#(
    parameter int NUM_ALT  = 4,
    parameter int DIV_LOG  = 4,
    parameter int HOLD_CYC = 45
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ALT-1:0] alt_clk,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_rdata,
    output logic               cfg_busy,
    output logic               tick
);
    tcp_cfg_t                      cfg;
    logic                          busy_next;
    logic [NUM_ALT-1:0][DIV_LOG:0] taps;

    tcp_cfg_guard #(.HOLD_CYC(HOLD_CYC)) guard_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (cfg_we),
        .wdata       (tcp_cfg_t'(cfg_wdata)),
        .cfg_o       (cfg),
        .busy_o      (cfg_busy),
        .busy_next_o (busy_next)
    );

    for (genvar g = 0; g < NUM_ALT; g++) begin : g_div
        tcp_src_div #(.DIV_LOG(DIV_LOG)) div_i (
            .aclk  (alt_clk[g]),
            .rst_n (rst_n),
            .tap_o (taps[g])
        );
    end

    tcp_tick_gen #(.NUM_ALT(NUM_ALT), .DIV_LOG(DIV_LOG)) tick_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .taps       (taps),
        .cfg        (cfg),
        .quiet_next (busy_next),
        .tick_o     (tick)
    );

    assign cfg_rdata = cfg;

endmodule

// File: rtl/tcp_checker.sv
`timescale 1ns/1ps
module tcp_checker #(
    parameter int CFG_W   = 6,
    parameter int NUM_ALT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             cfg_busy,
    input logic             tick
);
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R5: accepted write is stored and opens the window
    a_r5_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_busy) |=> (cfg_busy && cfg_rdata == $past(cfg_wdata)));

    // R6: writes during the window leave the stored word alone
    a_r6_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_busy) |=> $stable(cfg_rdata));

    // R7: no tick while the window is open
    a_r7_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_busy |-> !tick);

    // R8: reserved sources never tick
    a_r8_reserved_src: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cfg_rdata[2:0]) > NUM_ALT) |-> !tick);

    // R2: system clock source ticks every idle cycle
    a_r2_sys_every: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && cfg_rdata[2:0] == 3'd0 && !cfg_busy) |-> tick);

    // R3: alternate-source ticks last a single cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cfg_rdata[2:0] != 3'd0) |=> !tick);

endmodule

bind tmr_clk_presc tcp_checker #(.CFG_W(6), .NUM_ALT(NUM_ALT)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cfg_busy  (cfg_busy),
    .tick      (tick)
);

// File: tb/tmr_clk_presc_tb_top.sv
`timescale 1ns/1ps
module tmr_clk_presc_tb_top;

    localparam int HOLD = 45;
    localparam int WIN  = 1500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] alt_clk = 4'b0;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_wdata = '0;
    logic [5:0] cfg_rdata;
    logic       cfg_busy;
    logic       tick;

    int n_tests = 0;
    int n_fail  = 0;
    int alt_edges [4] = '{0, 0, 0, 0};

    always #10 clk = ~clk;              // 50 MHz
    always #50  alt_clk[0] = ~alt_clk[0];
    always #70  alt_clk[1] = ~alt_clk[1];
    always #90  alt_clk[2] = ~alt_clk[2];
    always #130 alt_clk[3] = ~alt_clk[3];

    always @(posedge alt_clk[0]) alt_edges[0] <= alt_edges[0] + 1;
    always @(posedge alt_clk[1]) alt_edges[1] <= alt_edges[1] + 1;
    always @(posedge alt_clk[2]) alt_edges[2] <= alt_edges[2] + 1;
    always @(posedge alt_clk[3]) alt_edges[3] <= alt_edges[3] + 1;

    tmr_clk_presc dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .alt_clk   (alt_clk),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg_busy  (cfg_busy),
        .tick      (tick)
    );

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int div_log(input int psc);
        return (psc > 4) ? 4 : psc;
    endfunction

    function automatic int exp_ticks(input int src, input int psc,
                                     input int cycles, input int edges);
        if (src == 0) return cycles;
        if (src > 4)  return 0;
        return edges >> div_log(psc);
    endfunction

    // Called at a negedge; returns at the following negedge
    task automatic drive_write(input logic [5:0] w);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic measure(input int src, input int psc);
        int busy_ticks = 0;
        int ticks = 0;
        int dbl = 0;
        int e0 = 0;
        int e1 = 0;
        int exp;
        int tol;
        bit prev_t = 1'b0;
        string rq;
        @(negedge clk);
        while (cfg_busy) @(negedge clk);
        drive_write({psc[2:0], src[2:0]});
        chk(cfg_rdata == {psc[2:0], src[2:0]}, "R5 readback",
            int'(cfg_rdata), int'({psc[2:0], src[2:0]}));
        while (cfg_busy) begin
            busy_ticks += int'(tick);
            @(negedge clk);
        end
        chk(busy_ticks == 0, "R7 no tick while busy", busy_ticks, 0);
        repeat (4) @(negedge clk);
        if (src >= 1 && src <= 4) e0 = alt_edges[src-1];
        for (int c = 0; c < WIN; c++) begin
            ticks += int'(tick);
            if (prev_t && tick) dbl++;
            prev_t = tick;
            @(negedge clk);
        end
        if (src >= 1 && src <= 4) e1 = alt_edges[src-1];
        exp = exp_ticks(src, psc, WIN, e1 - e0);
        tol = (src >= 1 && src <= 4) ? 2 : 0;
        if (src == 0)        rq = "R2 system source rate";
        else if (src > 4)    rq = "R8 reserved source silent";
        else if (psc > 4)    rq = "R9 spare prescale is /16";
        else                 rq = "R4 prescale rate";
        chk((ticks - exp <= tol) && (exp - ticks <= tol), rq, ticks, exp);
        if (src != 0) chk(dbl == 0, "R3 single-cycle ticks", dbl, 0);
    endtask

    initial begin : watchdog
        #(200000 * 20);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int unsigned sd;
        int busy_len;
        sd = $urandom(32'h5eed_0017);

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(cfg_rdata == 6'd0 && !cfg_busy, "R1 in reset", int'(cfg_rdata), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_rdata == 6'd0 && !cfg_busy, "R1 after release", int'(cfg_rdata), 0);

        // R2: default source ticks every cycle
        begin
            int t = 0;
            @(negedge clk);
            for (int c = 0; c < 100; c++) begin
                t += int'(tick);
                @(negedge clk);
            end
            chk(t == 100, "R2 default ticks", t, 100);
        end

        // R5/R6: window length and the 45th/46th edge boundary
        drive_write(6'o21);              // accepted at edge e0
        busy_len = 0;
        for (int k = 1; k <= 44; k++) begin
            busy_len += int'(cfg_busy);
            @(negedge clk);
        end
        busy_len += int'(cfg_busy);
        drive_write(6'o32);              // at edge e0+45: dropped
        chk(busy_len == HOLD, "R5 busy length", busy_len, HOLD);
        chk(!cfg_busy, "R5 busy ends", int'(cfg_busy), 0);
        chk(cfg_rdata == 6'o21, "R6 write at edge 45 dropped", int'(cfg_rdata), 'o21);
        drive_write(6'o43);              // at edge e0+46: accepted
        chk(cfg_rdata == 6'o43, "R6 write at edge 46 accepted", int'(cfg_rdata), 'o43);

        // R6: a write inside the window does not restart it
        @(negedge clk);
        while (cfg_busy) @(negedge clk);
        drive_write(6'o10);
        repeat (9) @(negedge clk);
        drive_write(6'o77);
        busy_len = 11;
        while (cfg_busy) begin
            busy_len++;
            @(negedge clk);
        end
        chk(busy_len == HOLD + 1 && cfg_rdata == 6'o10, "R6 no restart",
            busy_len, HOLD + 1);

        // Directed corner cases
        measure(0, 7);
        measure(1, 0);
        measure(2, 1);
        measure(3, 2);
        measure(4, 3);
        measure(1, 4);
        measure(1, 5);
        measure(2, 7);
        measure(5, 0);
        measure(7, 2);

        // Random configurations
        for (int r = 0; r < 8; r++) begin
            measure(int'($urandom % 8), int'($urandom % 8));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule